// File: doc/BRIEF.md
# Preamble-Trained Subpixel Word Aligner

This block sits behind the sampling front end of a display-panel receiver. Each tick of the subpixel clock delivers ten freshly sampled serial bits with no framing known. The block recovers the 10-bit subpixel word boundary and emits parallel pixel words tagged with their colour slot. A separate 1-bit VSYNC indication, decoded upstream from the clock line, marks the start of vertical blanking.

During blanking the transmitter repeats a framing word of five ones followed by five zeros. The block tests every one of the ten possible bit offsets on each word. It freezes the first offset that matches the framing word on enough consecutive words. After that it waits for the first word that is not a framing word. That word is a header whose low nibble gives the number of command words to follow. The command words are delivered on their own strobe. All later words are pixel data in R, G, B rotation until the next VSYNC.

Top module: `subpix_aligner`

## Requirements
- R1: While reset is asserted, and right after it is released, pix_valid, cmd_valid, locked and align_error are all 0. Reset is asynchronous and active low.
- R2: Before the first vsync_detect pulse the block is idle. No input pattern, including framing words and headers, raises pix_valid, cmd_valid, locked or align_error.
- R3: Take the rising edge on which vsync_detect is sampled high as edge 0, and let the framing word (10'b1111100000, first bit received = bit 9) start in the word presented for edge 1. Then locked is high from edge 6, i.e. right after the fourth consecutive matching window at one offset. Each non-framing word before the framing run delays this by one edge.
- R4: The boundary can sit at any of the ten bit offsets of the incoming words. After lock, every delivered word equals the transmitted 10-bit symbol, first bit received in bit 9. The offset stays frozen until the next vsync_detect.
- R5: The first non-framing word at the frozen offset that follows a framing word is the header, and its bits 3:0 give N (0 to 15). Exactly N cmd_valid pulses follow, the first one at edge H+4, where H is the header's symbol index after edge 0. The pulses carry the command words in the order they were sent. N = 0 goes straight to pixel output.
- R6: Pixel words begin at edge H+N+4 with pix_valid high on every word. pix_rgb cycles 0 (R), 1 (G), 2 (B) and starts at 0 on the first pixel of each frame. It never takes the value 3.
- R7: Framing words after lock and before the header produce no output strobes. Neither do non-framing words seen before lock.
- R8: If 64 words of blanking pass without lock, align_error is set (from edge 64) and locked stays 0. The header search and decoding then continue at the offset kept from the previous frame.
- R9: A vsync_detect pulse in any state clears pix_valid, cmd_valid, locked and align_error on the following edge and restarts training.
- R10: pix_valid and cmd_valid are never high together. Every command word is followed by another command word or by a pixel word, unless a vsync_detect pulse intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subpixel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_detect | input | 1 | One-cycle blanking-start indication |
| rx_bits | input | 10 | Ten raw bits per word clock, earliest in bit 9 |
| pix_valid | output | 1 | Pixel word strobe |
| pix_word | output | 10 | Aligned pixel word |
| pix_rgb | output | 2 | Colour slot: 0 R, 1 G, 2 B |
| cmd_valid | output | 1 | Command word strobe |
| cmd_word | output | 10 | Aligned command word |
| locked | output | 1 | Framing found in the current blanking period |
| align_error | output | 1 | Training timed out; previous offset in use |

## Verification
The bench sends the same frame structure at bit shifts 0, 3, 5, 7 and 9. A wrong window selection or a lock at the wrong offset therefore shows up as corrupted pixel and command words rather than going unnoticed. Frames vary the framing-run length, the command count (0, 1, 2, 3, 15) and the amount of junk placed before the framing run. These cases separate a correct lock latency from early or late locking, and check that the header is taken only after a framing word. A frame with no framing word before the timeout, sent at the previous shift, shows whether the old offset is really kept. The VSYNC that ends each active frame confirms that pixel output stops and the status flags clear.

// File: rtl/subpix_pkg.sv
package subpix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRAIN  = 2'd1,
    ST_CMD    = 2'd2,
    ST_ACTIVE = 2'd3
  } seq_state_t;

  // colour slot rotation R(0) -> G(1) -> B(2) -> R(0)
  function automatic logic [1:0] rgb_advance(input logic [1:0] cur);
    return (cur == 2'd2) ? 2'd0 : cur + 2'd1;
  endfunction

endpackage

// File: rtl/subpix_window.sv
module subpix_window #(
  parameter int W     = 10,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     rx_bits,
  input  logic [OFF_W-1:0] sel_off,
  output logic [W-1:0]     match_vec,
  output logic [W-1:0]     word_aligned
);
  localparam logic [W-1:0] PRE = {{(W/2){1'b1}}, {(W-W/2){1'b0}}};

  logic [W-1:0]   cur_q, prev_q;
  logic [2*W-1:0] hist;
  logic [W-1:0]   win [W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= cur_q;
      cur_q  <= rx_bits;
    end
  end

  assign hist = {prev_q, cur_q};

  // window k starts k bits into the older word
  for (genvar k = 0; k < W; k++) begin : g_win
    assign win[k]       = hist[2*W-1-k -: W];
    assign match_vec[k] = (win[k] == PRE);
  end

  always_comb begin
    word_aligned = win[0];
    for (int k = 1; k < W; k++) begin
      if (sel_off == OFF_W'(k)) word_aligned = win[k];
    end
  end
endmodule

// File: rtl/subpix_lock.sv
module subpix_lock #(
  parameter int W         = 10,
  parameter int OFF_W     = 4,
  parameter int LOCK_RUN  = 4,
  parameter int TMO_WORDS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             search_en,
  input  logic [W-1:0]     match_vec,
  output logic             lock_hit,
  output logic             tmo_hit,
  output logic [OFF_W-1:0] off_q
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int TMO_W = $clog2(TMO_WORDS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_WORDS - 1);

  logic [RUN_W-1:0] run [W];
  logic [W-1:0]     hit_vec;
  logic [OFF_W-1:0] hit_off;
  logic [TMO_W-1:0] tmo_cnt;

  // one run-length counter per candidate offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < W; k++) run[k] <= '0;
    end else begin
      for (int k = 0; k < W; k++) begin
        if (restart || !search_en || !match_vec[k]) run[k] <= '0;
        else                                        run[k] <= run[k] + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_hit
    assign hit_vec[k] = search_en && match_vec[k] && (run[k] == RUN_LAST);
  end

  always_comb begin
    hit_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_off = OFF_W'(k);
    end
  end

  assign lock_hit = |hit_vec;
  assign tmo_hit  = search_en && !lock_hit && (tmo_cnt == TMO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt <= '0;
      off_q   <= '0;
    end else begin
      if (restart)                             tmo_cnt <= '0;
      else if (search_en && tmo_cnt != TMO_LAST) tmo_cnt <= tmo_cnt + 1'b1;
      if (lock_hit && !restart) off_q <= hit_off;
    end
  end
endmodule

// File: rtl/subpix_seq.sv
module subpix_seq
  import subpix_pkg::*;
#(
  parameter int W     = 10,
  parameter int HDR_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vsync_detect,
  input  logic         lock_hit,
  input  logic         tmo_hit,
  input  logic [W-1:0] word,
  output logic         search_en,
  output logic         pix_valid,
  output logic [W-1:0] pix_word,
  output logic [1:0]   pix_rgb,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_word,
  output logic         locked,
  output logic         align_error
);
  localparam logic [W-1:0] PRE = {{(W/2){1'b1}}, {(W-W/2){1'b0}}};

  seq_state_t       state;
  logic             trained, seen_pre;
  logic [HDR_W-1:0] cmd_left, hdr_cnt;
  logic [1:0]       rgb_ctr;
  logic             is_pre;

  assign is_pre    = (word == PRE);
  assign hdr_cnt   = word[HDR_W-1:0];
  assign search_en = (state == ST_TRAIN) && !trained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      trained     <= 1'b0;
      seen_pre    <= 1'b0;
      cmd_left    <= '0;
      rgb_ctr     <= 2'd0;
      pix_valid   <= 1'b0;
      pix_word    <= '0;
      pix_rgb     <= 2'd0;
      cmd_valid   <= 1'b0;
      cmd_word    <= '0;
      locked      <= 1'b0;
      align_error <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      cmd_valid <= 1'b0;
      if (vsync_detect) begin
        state       <= ST_TRAIN;
        trained     <= 1'b0;
        seen_pre    <= 1'b0;
        locked      <= 1'b0;
        align_error <= 1'b0;
        rgb_ctr     <= 2'd0;
      end else begin
        case (state)
          ST_IDLE: ;
          ST_TRAIN: begin
            if (!trained) begin
              if (lock_hit) begin
                trained  <= 1'b1;
                locked   <= 1'b1;
                seen_pre <= 1'b1;
              end else if (tmo_hit) begin
                trained     <= 1'b1;
                align_error <= 1'b1;
              end
            end else if (is_pre) begin
              seen_pre <= 1'b1;
            end else if (seen_pre) begin
              cmd_left <= hdr_cnt;
              rgb_ctr  <= 2'd0;
              state    <= (hdr_cnt == '0) ? ST_ACTIVE : ST_CMD;
            end
          end
          ST_CMD: begin
            cmd_valid <= 1'b1;
            cmd_word  <= word;
            cmd_left  <= cmd_left - 1'b1;
            if (cmd_left == HDR_W'(1)) state <= ST_ACTIVE;
          end
          ST_ACTIVE: begin
            pix_valid <= 1'b1;
            pix_word  <= word;
            pix_rgb   <= rgb_ctr;
            rgb_ctr   <= rgb_advance(rgb_ctr);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/subpix_aligner.sv
module subpix_aligner #(
  parameter int WORD_W    = 10,
  parameter int LOCK_RUN  = 4,
  parameter int TMO_WORDS = 64,
  parameter int HDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_detect,
  input  logic [WORD_W-1:0] rx_bits,
  output logic              pix_valid,
  output logic [WORD_W-1:0] pix_word,
  output logic [1:0]        pix_rgb,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic              locked,
  output logic              align_error
);
  localparam int OFF_W = $clog2(WORD_W);

  logic [WORD_W-1:0] match_vec;
  logic [WORD_W-1:0] word_aligned;
  logic [OFF_W-1:0]  off_q;
  logic              lock_hit;
  logic              tmo_hit;
  logic              search_en;

  subpix_window #(.W(WORD_W), .OFF_W(OFF_W)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_bits      (rx_bits),
    .sel_off      (off_q),
    .match_vec    (match_vec),
    .word_aligned (word_aligned)
  );

  subpix_lock #(
    .W(WORD_W), .OFF_W(OFF_W), .LOCK_RUN(LOCK_RUN), .TMO_WORDS(TMO_WORDS)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (vsync_detect),
    .search_en (search_en),
    .match_vec (match_vec),
    .lock_hit  (lock_hit),
    .tmo_hit   (tmo_hit),
    .off_q     (off_q)
  );

  subpix_seq #(.W(WORD_W), .HDR_W(HDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync_detect (vsync_detect),
    .lock_hit     (lock_hit),
    .tmo_hit      (tmo_hit),
    .word         (word_aligned),
    .search_en    (search_en),
    .pix_valid    (pix_valid),
    .pix_word     (pix_word),
    .pix_rgb      (pix_rgb),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .locked       (locked),
    .align_error  (align_error)
  );
endmodule

// File: rtl/subpix_aligner_chk.sv
module subpix_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync_detect,
  input logic       pix_valid,
  input logic [1:0] pix_rgb,
  input logic       cmd_valid,
  input logic       locked,
  input logic       align_error,
  input logic       lock_hit,
  input logic       tmo_hit,
  input logic       search_en
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && cmd_valid));

  // R10
  cmd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !vsync_detect) |=> (cmd_valid || pix_valid));

  // R9
  vsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_detect |=> (!pix_valid && !cmd_valid && !locked && !align_error));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && align_error));

  // R3
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && !vsync_detect) |=> locked);

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !search_en);

  // R8
  tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !vsync_detect) |=> (align_error && !locked));

  // R6
  rgb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_rgb != 2'd3));

  // R6
  rgb_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (pix_rgb == 2'd0));

  // R6
  rgb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !vsync_detect) |=>
      (pix_valid && pix_rgb == (($past(pix_rgb) == 2'd2) ? 2'd0 : $past(pix_rgb) + 2'd1)));
endmodule

bind subpix_aligner subpix_aligner_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vsync_detect (vsync_detect),
  .pix_valid    (pix_valid),
  .pix_rgb      (pix_rgb),
  .cmd_valid    (cmd_valid),
  .locked       (locked),
  .align_error  (align_error),
  .lock_hit     (lock_hit),
  .tmo_hit      (tmo_hit),
  .search_en    (search_en)
);

// File: tb/subpix_aligner_bench.sv
module subpix_aligner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0;
  logic [9:0] rx = '0;
  logic       pix_valid, cmd_valid, locked, align_error;
  logic [9:0] pix_word, cmd_word;
  logic [1:0] pix_rgb;

  always #2 clk = ~clk;

  subpix_aligner u_subpix_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync_detect (vsync),
    .rx_bits      (rx),
    .pix_valid    (pix_valid),
    .pix_word     (pix_word),
    .pix_rgb      (pix_rgb),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .locked       (locked),
    .align_error  (align_error)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [9:0] FRAMING = 10'b1111100000;

  // per frame: bit shift, framing words, command count, pixel count, junk words before framing
  localparam int FRM_N = 6;
  localparam int FRM [FRM_N][5] = '{
    '{0, 4,  2, 7,  0},
    '{3, 6,  0, 5,  0},
    '{5, 5,  2, 4,  3},
    '{9, 5, 15, 4,  0},
    '{7, 4,  1, 6,  0},
    '{7, 2,  3, 5, 66}
  };

  logic [9:0] sym [0:127];
  int nsym;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sbit(input int q);
    int idx = q / 10;
    if (idx >= nsym) return 1'b0;
    return sym[idx][9 - (q % 10)];
  endfunction

  function automatic logic [9:0] sword(input int n, input int s);
    logic [9:0] w;
    for (int b = 0; b < 10; b++) begin
      int p = 10 * n + b;
      w[9 - b] = (p < s) ? 1'b0 : sbit(p - s);
    end
    return w;
  endfunction

  task automatic run_frame(input int s, input int npre, input int ncmd, input int npix, input int junk);
    int hdr;
    int d_lock = -1, d_err = -1, d_cmd = -1, d_pix = -1;
    int nc = 0, np = 0;
    logic [9:0] cap_cmd [0:31];
    logic [9:0] cap_pix [0:31];
    logic [1:0] cap_rgb [0:31];
    nsym = 0;
    for (int i = 0; i < junk; i++) begin sym[nsym] = '0; nsym++; end
    for (int i = 0; i < npre; i++) begin sym[nsym] = FRAMING; nsym++; end
    hdr = nsym;
    sym[nsym] = {6'b101101, 4'(ncmd)}; nsym++;
    for (int i = 0; i < ncmd; i++) begin sym[nsym] = 10'((677 + 23 * i + 5 * s) % 1024); nsym++; end
    for (int i = 0; i < npix; i++) begin sym[nsym] = 10'((131 * i + 59 * s + 17) % 1024); nsym++; end

    @(negedge clk);
    vsync = 1'b1;
    rx    = '0;
    for (int i = 0; i < nsym + 5; i++) begin
      @(negedge clk);
      if (i == 0)
        chk(!pix_valid && !cmd_valid && !locked && !align_error, "R9 outputs cleared after vsync",
            int'({pix_valid, cmd_valid, locked, align_error}), 0);
      if (locked && d_lock < 0) d_lock = i;
      if (align_error && d_err < 0) d_err = i;
      if (cmd_valid) begin
        if (d_cmd < 0) d_cmd = i;
        if (nc < 32) cap_cmd[nc] = cmd_word;
        nc++;
      end
      if (pix_valid) begin
        if (d_pix < 0) d_pix = i;
        if (np < 32) begin cap_pix[np] = pix_word; cap_rgb[np] = pix_rgb; end
        np++;
      end
      vsync = 1'b0;
      rx    = sword(i, s);
    end

    if (junk < 64) begin
      chk(d_lock == junk + 6, "R3 lock edge", d_lock, junk + 6);
      chk(d_err < 0, "R8 no error when locked", d_err, -1);
    end else begin
      chk(d_err == 64, "R8 timeout edge", d_err, 64);
      chk(d_lock < 0, "R8 locked stays low", d_lock, -1);
    end
    chk(nc == ncmd, "R5 command count", nc, ncmd);
    if (ncmd > 0) chk(d_cmd == hdr + 4, "R5 first command edge", d_cmd, hdr + 4);
    for (int c = 0; c < ncmd && c < nc; c++)
      chk(cap_cmd[c] == sym[hdr + 1 + c], "R5 command word", int'(cap_cmd[c]), int'(sym[hdr + 1 + c]));
    // R7: nothing strobed before the header is consumed
    chk(d_pix == hdr + ncmd + 4, "R7 R6 first pixel edge", d_pix, hdr + ncmd + 4);
    for (int p = 0; p < npix && p < np; p++) begin
      chk(cap_pix[p] == sym[hdr + 1 + ncmd + p], "R4 pixel word", int'(cap_pix[p]),
          int'(sym[hdr + 1 + ncmd + p]));
      chk(cap_rgb[p] == 2'(p % 3), "R6 colour slot", int'(cap_rgb[p]), p % 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!pix_valid && !cmd_valid && !locked && !align_error, "R1 outputs in reset",
        int'({pix_valid, cmd_valid, locked, align_error}), 0);
    rst_n = 1'b1;

    // R2: framing words and a header with no vsync must do nothing
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!pix_valid && !cmd_valid && !locked && !align_error, "R2 idle before vsync",
          int'({pix_valid, cmd_valid, locked, align_error}), 0);
      rx = (i < 9) ? FRAMING : 10'b1011010010;
    end

    for (int f = 0; f < FRM_N; f++)
      run_frame(FRM[f][0], FRM[f][1], FRM[f][2], FRM[f][3], FRM[f][4]);

    // R1: asynchronous reset while pixels are streaming
    @(negedge clk);
    chk(pix_valid == 1'b1, "R6 streaming before reset", int'(pix_valid), 1);
    rst_n = 1'b0;
    #1;
    chk(!pix_valid && !cmd_valid && !locked && !align_error, "R1 async reset clears",
        int'({pix_valid, cmd_valid, locked, align_error}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rx    = FRAMING;
    repeat (3) @(negedge clk);
    chk(!pix_valid && !locked, "R2 idle after reset", int'({pix_valid, locked}), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule